// File: doc/BRIEF.md
# Clock Source Qualification Monitor

One instance of this block watches one nominated synchronization clock source. It decides whether that source may be offered to the clock selector. It also reports the quality level the selector should give the source.

The raw loss-of-signal indication is filtered in two different ways depending on its direction:

- **Going bad.** A loss only counts once it has lasted a configurable hold-off time. A shorter glitch leaves the source available.
- **Coming back.** Once a counted loss ends, a wait-to-restore (WTR) period must run out before the source is offered again. Software can end this period early with a one-cycle clear pulse.

Both periods are counted in pulses of a prescaled tick input, not in clock cycles.

The effective quality level comes from two places: an overwrite value from configuration and the level carried in received SSM messages. When the overwrite is set, it beats any received level. When SSM is turned off, the overwrite is used as if it had been received. An unknown quality is reported as the lowest possible quality.

Top module: `clk_src_qual_mon`

## Requirements
- R1: After reset `avail_o`=1, `los_o`=0, `wtr_act_o`=0, `ssm_fail_o`=0 and `eff_ql_o`=4'hF.
- R2: If `los_raw_i` stays high, `los_o` rises and `avail_o` falls on the edge that counts the `holdoff_i`-th tick. Ticks are counted from the edge after the edge where the loss was first seen. Edges with `tick_i` low do not count.
- R3: A loss that clears before the hold-off count is reached leaves `avail_o` high throughout, and `los_o` stays low.
- R4: With `holdoff_i`=0, a loss sets `los_o` on the first edge where `los_raw_i` is seen high.
- R5: When a counted loss clears, `wtr_act_o` rises and `avail_o` stays low. `avail_o` returns on the edge that counts the `wtr_i`-th tick, and `wtr_act_o` falls on that same edge.
- R6: With `wtr_i`=0, `avail_o` returns on the first edge where `los_raw_i` is seen low after a counted loss.
- R7: A `clr_wtr_i` pulse while `wtr_act_o` is high and `los_raw_i` is low sets `avail_o` on that edge.
- R8: A loss during WTR returns the block at once to `los_o`=1. When that loss clears, the full WTR count starts again from zero.
- R9: Quality codes are 4 bits, smaller means better, and 4'hF means unknown. A value of `ovr_ql_i` other than 4'hF replaces any received level. `eff_ql_o` shows the result one edge later.
- R10: With `ssm_en_i`=0, `eff_ql_o` equals `ovr_ql_i` one edge later, and that includes the value 4'hF.
- R11: With `ssm_en_i`=1 and `ovr_ql_i`=4'hF, `eff_ql_o` one edge later follows the state of `ssm_valid_i`:
  - if `ssm_valid_i` is high, `eff_ql_o` is `ssm_ql_i`;
  - if `ssm_valid_i` is low, `eff_ql_o` is 4'hF.
- R12: `ssm_fail_o` is high one edge after any cycle with `ssm_en_i`=1 and `ssm_valid_i`=0, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled timer tick |
| los_raw_i | input | 1 | Unfiltered loss of signal |
| ssm_en_i | input | 1 | SSM processing enabled for this source |
| ssm_valid_i | input | 1 | SSM currently received correctly |
| ssm_ql_i | input | 4 | Received quality level |
| ovr_ql_i | input | 4 | Overwrite quality level, 4'hF = not set |
| holdoff_i | input | HOLD_W | Hold-off time in ticks |
| wtr_i | input | WTR_W | Wait-to-restore time in ticks |
| clr_wtr_i | input | 1 | Pulse that ends WTR early |
| avail_o | output | 1 | Source qualified for selection |
| eff_ql_o | output | 4 | Effective quality level |
| los_o | output | 1 | Filtered loss status |
| ssm_fail_o | output | 1 | SSM enabled but not received |
| wtr_act_o | output | 1 | WTR timer running |

## Verification
The assertions assume that `holdoff_i` and `wtr_i` change only while the source is available and no loss is pending. A limit that changes in the middle of a count could end a period early or late. The bench therefore loads each hold-off and WTR setting in an idle cycle before the loss pulse starts. It holds those settings until the sequence has settled back to available. Every sweep drives `tick_i` high on every edge, except one run that deliberately holds it low to show that counting stops.

// File: rtl/csq_pkg.sv
package csq_pkg;
    localparam int QL_W = 4;
    localparam logic [QL_W-1:0] QL_NONE = 4'hF;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOST = 2'd2,
        ST_WTR  = 2'd3
    } flt_state_e;
endpackage

// File: rtl/csq_loss_filter.sv
module csq_loss_filter
    import csq_pkg::*;
#(
    parameter int HOLD_W = 8,
    parameter int WTR_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              los_raw_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    input  logic [WTR_W-1:0]  wtr_i,
    input  logic              clr_wtr_i,
    output logic              avail_o,
    output logic              los_o,
    output logic              wtr_act_o
);
    localparam int CW = (HOLD_W > WTR_W) ? HOLD_W : WTR_W;

    typedef struct packed {
        flt_state_e    st;
        logic [CW-1:0] cnt;
    } flt_reg_t;

    flt_reg_t     r_d, r_q;
    logic [CW:0]  inc;
    logic [CW:0]  hold_lim;
    logic [CW:0]  wtr_lim;

    assign hold_lim = {{(CW + 1 - HOLD_W){1'b0}}, holdoff_i};
    assign wtr_lim  = {{(CW + 1 - WTR_W){1'b0}}, wtr_i};
    assign inc      = {1'b0, r_q.cnt} + {{CW{1'b0}}, 1'b1};

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_OK: begin
                if (los_raw_i) begin
                    r_d.cnt = '0;
                    r_d.st  = (holdoff_i == '0) ? ST_LOST : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!los_raw_i) begin
                    r_d.st = ST_OK;
                end else if (tick_i) begin
                    r_d.cnt = inc[CW-1:0];
                    if (inc >= hold_lim) r_d.st = ST_LOST;
                end
            end
            ST_LOST: begin
                if (!los_raw_i) begin
                    r_d.cnt = '0;
                    r_d.st  = (wtr_i == '0) ? ST_OK : ST_WTR;
                end
            end
            ST_WTR: begin
                if (los_raw_i) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_LOST;
                end else if (clr_wtr_i) begin
                    r_d.st = ST_OK;
                end else if (tick_i) begin
                    r_d.cnt = inc[CW-1:0];
                    if (inc >= wtr_lim) r_d.st = ST_OK;
                end
            end
            default: r_d.st = ST_OK;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st  <= ST_OK;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign avail_o   = (r_q.st == ST_OK) || (r_q.st == ST_HOLD);
    assign los_o     = (r_q.st == ST_LOST);
    assign wtr_act_o = (r_q.st == ST_WTR);

    AST_LOST_NOT_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        los_o |-> (!avail_o && !wtr_act_o)); // R2
    AST_NO_TICK_NO_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (avail_o && !tick_i && holdoff_i != '0) |=> avail_o); // R2
    AST_CLEAR_KEEPS_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (avail_o && !los_raw_i) |=> avail_o); // R3
    AST_WTR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wtr_act_o |-> !avail_o); // R5
    AST_CLR_RESTORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wtr_act_o && clr_wtr_i && !los_raw_i) |=> avail_o); // R7
    AST_LOSS_IN_WTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wtr_act_o && los_raw_i) |=> los_o); // R8
endmodule

// File: rtl/csq_ql_select.sv
module csq_ql_select
    import csq_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ssm_en_i,
    input  logic            ssm_valid_i,
    input  logic [QL_W-1:0] ssm_ql_i,
    input  logic [QL_W-1:0] ovr_ql_i,
    output logic [QL_W-1:0] eff_ql_o,
    output logic            ssm_fail_o
);
    typedef struct packed {
        logic [QL_W-1:0] ql;
        logic            fail;
    } ql_reg_t;

    ql_reg_t q_d, q_q;

    always_comb begin
        q_d.fail = ssm_en_i && !ssm_valid_i;
        if (!ssm_en_i || ovr_ql_i != QL_NONE) begin
            q_d.ql = ovr_ql_i;
        end else if (ssm_valid_i) begin
            q_d.ql = ssm_ql_i;
        end else begin
            q_d.ql = QL_NONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_q.ql   <= QL_NONE;
            q_q.fail <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign eff_ql_o   = q_q.ql;
    assign ssm_fail_o = q_q.fail;

    AST_OVR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ssm_en_i && ovr_ql_i != QL_NONE) |=> (eff_ql_o == $past(ovr_ql_i))); // R9
    AST_NO_SSM_USES_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ssm_en_i |=> (eff_ql_o == $past(ovr_ql_i))); // R10
    AST_FAIL_GIVES_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ssm_en_i && !ssm_valid_i && ovr_ql_i == QL_NONE) |=> (eff_ql_o == QL_NONE && ssm_fail_o)); // R11
endmodule

// File: rtl/clk_src_qual_mon.sv
module clk_src_qual_mon
    import csq_pkg::*;
#(
    parameter int HOLD_W = 8,
    parameter int WTR_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              los_raw_i,
    input  logic              ssm_en_i,
    input  logic              ssm_valid_i,
    input  logic [3:0]        ssm_ql_i,
    input  logic [3:0]        ovr_ql_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    input  logic [WTR_W-1:0]  wtr_i,
    input  logic              clr_wtr_i,
    output logic              avail_o,
    output logic [3:0]        eff_ql_o,
    output logic              los_o,
    output logic              ssm_fail_o,
    output logic              wtr_act_o
);
    csq_loss_filter #(
        .HOLD_W (HOLD_W),
        .WTR_W  (WTR_W)
    ) u_filter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .los_raw_i (los_raw_i),
        .holdoff_i (holdoff_i),
        .wtr_i     (wtr_i),
        .clr_wtr_i (clr_wtr_i),
        .avail_o   (avail_o),
        .los_o     (los_o),
        .wtr_act_o (wtr_act_o)
    );

    csq_ql_select u_ql (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ssm_en_i    (ssm_en_i),
        .ssm_valid_i (ssm_valid_i),
        .ssm_ql_i    (ssm_ql_i),
        .ovr_ql_i    (ovr_ql_i),
        .eff_ql_o    (eff_ql_o),
        .ssm_fail_o  (ssm_fail_o)
    );

    AST_AVAIL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({avail_o, los_o, wtr_act_o}) == 1); // R5
endmodule

// File: tb/tb_clk_src_qual_mon.sv
`timescale 1ns/1ps
module tb_clk_src_qual_mon;
    localparam int CLK_PERIOD = 10;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       tick_i = 1'b1;
    logic       los_raw_i = 1'b0;
    logic       ssm_en_i = 1'b0;
    logic       ssm_valid_i = 1'b0;
    logic [3:0] ssm_ql_i = 4'h0;
    logic [3:0] ovr_ql_i = 4'hF;
    logic [7:0] holdoff_i = 8'd0;
    logic [7:0] wtr_i = 8'd0;
    logic       clr_wtr_i = 1'b0;
    logic       avail_o, los_o, ssm_fail_o, wtr_act_o;
    logic [3:0] eff_ql_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    clk_src_qual_mon dut (
        .clk_i, .rst_ni, .tick_i, .los_raw_i, .ssm_en_i, .ssm_valid_i,
        .ssm_ql_i, .ovr_ql_i, .holdoff_i, .wtr_i, .clr_wtr_i,
        .avail_o, .eff_ql_o, .los_o, .ssm_fail_o, .wtr_act_o
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_i);
        #1;
    endtask

    task automatic check_flt(input string req, input bit ea, input bit el, input bit ew);
        check(req, "avail_o", avail_o, ea);
        check(req, "los_o", los_o, el);
        check(req, "wtr_act_o", wtr_act_o, ew);
    endtask

    // Loss pulse of len edges, hold-off h, WTR w, tick every edge.
    task automatic run_pulse(input int h, input int len, input int w);
        bit rep;
        string req;
        @(negedge clk_i);
        holdoff_i = 8'(h);
        wtr_i = 8'(w);
        los_raw_i = 1'b0;
        step();
        rep = (len > h);
        for (int k = 0; k < len + w + 3; k++) begin
            @(negedge clk_i);
            los_raw_i = (k < len);
            step();
            if (k < len) req = (h == 0) ? "R4" : (rep ? "R2" : "R3");
            else req = (w == 0) ? "R6" : "R5";
            check_flt(req,
                      !(rep && k >= h && k < len + w),
                      rep && k >= h && k < len,
                      rep && k >= len && k < len + w);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 3);
        #1;
        check("R1", "avail_o", avail_o, 1);
        check("R1", "los_o", los_o, 0);
        check("R1", "wtr_act_o", wtr_act_o, 0);
        check("R1", "ssm_fail_o", ssm_fail_o, 0);
        check("R1", "eff_ql_o", eff_ql_o, 15);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // R2 R3 R4 R5 R6 sweep
        for (int h = 0; h < 4; h++)
            for (int len = 0; len < 6; len++)
                for (int w = 0; w < 4; w++)
                    run_pulse(h, len, w);

        // R2: without ticks the hold-off never expires
        @(negedge clk_i);
        holdoff_i = 8'd1; wtr_i = 8'd0; tick_i = 1'b0;
        los_raw_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            step();
            check_flt("R2", 1, 0, 0);
            @(negedge clk_i);
        end
        los_raw_i = 1'b0;
        step();
        check_flt("R3", 1, 0, 0);
        @(negedge clk_i);
        tick_i = 1'b1;

        // R7: clear ends WTR early
        holdoff_i = 8'd0; wtr_i = 8'd10;
        los_raw_i = 1'b1;
        step();
        check_flt("R7", 0, 1, 0);
        @(negedge clk_i);
        los_raw_i = 1'b0;
        step();
        check_flt("R7", 0, 0, 1);
        step();
        check_flt("R7", 0, 0, 1);
        @(negedge clk_i);
        clr_wtr_i = 1'b1;
        step();
        check_flt("R7", 1, 0, 0);
        @(negedge clk_i);
        clr_wtr_i = 1'b0;

        // R8: loss inside WTR restarts the full count
        wtr_i = 8'd3;
        los_raw_i = 1'b1;
        step();
        @(negedge clk_i);
        los_raw_i = 1'b0;
        step();
        step();
        check_flt("R8", 0, 0, 1);
        @(negedge clk_i);
        los_raw_i = 1'b1;
        step();
        check_flt("R8", 0, 1, 0);
        @(negedge clk_i);
        los_raw_i = 1'b0;
        step();
        check_flt("R8", 0, 0, 1);
        step();
        check_flt("R8", 0, 0, 1);
        step();
        check_flt("R8", 0, 0, 1);
        step();
        check_flt("R8", 1, 0, 0);

        // R9 R10 R11 R12 quality sweep
        for (int en = 0; en < 2; en++)
            for (int v = 0; v < 2; v++)
                for (int rq = 0; rq < 16; rq++)
                    for (int oq = 0; oq < 16; oq++) begin
                        int exp_ql;
                        string req;
                        @(negedge clk_i);
                        ssm_en_i = en[0]; ssm_valid_i = v[0];
                        ssm_ql_i = 4'(rq); ovr_ql_i = 4'(oq);
                        step();
                        if (en == 0) begin exp_ql = oq; req = "R10"; end
                        else if (oq != 15) begin exp_ql = oq; req = "R9"; end
                        else if (v == 1) begin exp_ql = rq; req = "R11"; end
                        else begin exp_ql = 15; req = "R11"; end
                        check(req, "eff_ql_o", eff_ql_o, exp_ql);
                        check("R12", "ssm_fail_o", ssm_fail_o, (en == 1 && v == 0) ? 1 : 0);
                    end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule